// File: doc/BRIEF.md
# Register-Mapped Factorial Unit with Interrupt Word

This block is a slave on a plain 32-bit register bus (address, write data, registered read data, separate read and write strobes, and a full-width qualifier). Software finds it through a fixed identification word, can check the bus path with a register that stores the inverse of whatever is written, and uses a sequential factorial engine. Writing an operand starts the engine, which performs one multiply per clock while counting the operand down. The register that took the operand holds the truncated product once the engine is idle again.

Software learns that a computation has finished either by polling a busy flag in the status word or by setting a completion-interrupt enable in that same word. An interrupt word collects event bits. Software can set bits in it through one offset and clear them through another. The engine's completion sets bit 0, and a single-cycle pulse from a neighbouring DMA engine sets bit 8. The level interrupt output is high whenever any bit of that word is set.

Top module: `fact_mmio_unit`

## Requirements
- R1: A full-width read of offset 0x00 returns 0x010000ED.
- R2: A full-width write to offset 0x04 stores the bitwise inverse of the write data, and a read of 0x04 returns the stored value (0 after reset).
- R3: A full-width write to offset 0x08 while idle loads the operand and sets the busy flag (bit 0 of offset 0x20). Such a write while busy has no effect on the operand or on the result.
- R4: When the busy flag drops, offset 0x08 reads n·(n−1)·…·1 modulo 2^32 for operand n, and an operand of 0 gives 1.
- R5: Bit 7 of offset 0x20 is a read/write completion-interrupt enable. A write to 0x20 changes only bit 7, and every other bit of a status read shows the busy flag in bit 0 and zeros elsewhere.
- R6: When a computation finishes with the enable set, bit 0 of the interrupt word becomes 1. When it finishes with the enable clear, the interrupt word is unchanged.
- R7: A write to 0x60 ORs the data into the interrupt word, a write to 0x64 clears the bits that are 1 in the data, and 0x24 reads the word. If a clear and a set hit the same bit in one cycle, the set wins.
- R8: The interrupt output is high exactly when the interrupt word is non-zero.
- R9: A write with the full-width qualifier low changes nothing. A read with the qualifier low, or a read of an offset other than 0x00, 0x04, 0x08, 0x20 or 0x24, returns 0xFFFFFFFF.
- R10: A one-cycle pulse on the DMA event input sets bit 8 of the interrupt word.
- R11: Read data appears on the read data port in the cycle after the read strobe, and stays there until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_full | input | 1 | High when the access is 32 bits wide |
| bus_rdata | output | 32 | Registered read data |
| dma_evt | input | 1 | One-cycle completion pulse from the DMA engine |
| irq_out | output | 1 | Level interrupt, high while the interrupt word is non-zero |

## Verification
The properties assume that read and write strobes are never high in the same cycle, and that the DMA event input is a single-cycle pulse. The bench drives every access through one task that raises exactly one strobe for one cycle and releases it on the falling edge, and it pulses the DMA input the same way. The factorial sweep covers operands 0 through 13, so the sweep includes the first truncated product, and it alternates the completion enable between operands. The set-wins rule is checked by sending a clear and a DMA pulse to bit 8 in the same cycle.

// File: rtl/fxa_pkg.sv
package fxa_pkg;
   localparam int unsigned OFF_ID    = 'h00;
   localparam int unsigned OFF_TEST  = 'h04;
   localparam int unsigned OFF_OPER  = 'h08;
   localparam int unsigned OFF_STAT  = 'h20;
   localparam int unsigned OFF_IWORD = 'h24;
   localparam int unsigned OFF_ISET  = 'h60;
   localparam int unsigned OFF_ICLR  = 'h64;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_ID,
      SEL_TEST,
      SEL_OPER,
      SEL_STAT,
      SEL_IWORD
   } rd_sel_e;

   typedef struct packed {
      logic test;
      logic oper;
      logic stat;
      logic iset;
      logic iclr;
   } wr_strb_t;
endpackage

// File: rtl/fxa_decode.sv
module fxa_decode
   import fxa_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic              full,
   output wr_strb_t          wstrb,
   output logic              rd_go,
   output rd_sel_e           rsel
);
   localparam logic [ADDR_W-1:0] A_ID    = ADDR_W'(OFF_ID);
   localparam logic [ADDR_W-1:0] A_TEST  = ADDR_W'(OFF_TEST);
   localparam logic [ADDR_W-1:0] A_OPER  = ADDR_W'(OFF_OPER);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_IWORD = ADDR_W'(OFF_IWORD);
   localparam logic [ADDR_W-1:0] A_ISET  = ADDR_W'(OFF_ISET);
   localparam logic [ADDR_W-1:0] A_ICLR  = ADDR_W'(OFF_ICLR);

   logic wr_ok;
   assign wr_ok = wr && full;
   assign rd_go = rd;

   always_comb begin
      wstrb      = '0;
      wstrb.test = wr_ok && (addr == A_TEST);
      wstrb.oper = wr_ok && (addr == A_OPER);
      wstrb.stat = wr_ok && (addr == A_STAT);
      wstrb.iset = wr_ok && (addr == A_ISET);
      wstrb.iclr = wr_ok && (addr == A_ICLR);
   end

   always_comb begin
      rsel = SEL_NONE;
      if (full) begin
         unique case (addr)
            A_ID:    rsel = SEL_ID;
            A_TEST:  rsel = SEL_TEST;
            A_OPER:  rsel = SEL_OPER;
            A_STAT:  rsel = SEL_STAT;
            A_IWORD: rsel = SEL_IWORD;
            default: rsel = SEL_NONE;
         endcase
      end
   end
endmodule

// File: rtl/fxa_fact_engine.sv
module fxa_fact_engine #(
   parameter int DATA_W      = 32,
   parameter bit EXIT_AT_ONE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] operand,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] value
);
   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] cnt;
   logic              last;

   generate
      if (EXIT_AT_ONE) begin : g_exit_one
         assign last = (cnt <= DATA_W'(1));
      end else begin : g_exit_zero
         assign last = (cnt == '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc   <= '0;
         cnt   <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
         value <= '0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            value <= operand;
            cnt   <= operand;
            acc   <= DATA_W'(1);
            busy  <= 1'b1;
         end else if (busy) begin
            if (last) begin
               value <= acc;
               busy  <= 1'b0;
               done  <= 1'b1;
            end else begin
               acc <= acc * cnt;
               cnt <= cnt - DATA_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/fxa_irq_word.sv
module fxa_irq_word #(
   parameter int DATA_W   = 32,
   parameter int FACT_BIT = 0,
   parameter int DMA_BIT  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic              clr_en,
   input  logic [DATA_W-1:0] mask,
   input  logic              fact_evt,
   input  logic              dma_evt,
   output logic [DATA_W-1:0] word,
   output logic              level
);
   logic [DATA_W-1:0] sets;
   logic [DATA_W-1:0] clrs;

   always_comb begin
      sets = set_en ? mask : '0;
      sets[FACT_BIT] = sets[FACT_BIT] | fact_evt;
      sets[DMA_BIT]  = sets[DMA_BIT]  | dma_evt;
      clrs = clr_en ? mask : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) word <= '0;
      else        word <= (word & ~clrs) | sets;
   end

   assign level = |word;
endmodule

// File: rtl/fact_mmio_unit.sv
module fact_mmio_unit
   import fxa_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter int          DATA_W      = 32,
   parameter logic [31:0] ID_VALUE    = 32'h0100_00ED,
   parameter int          BUSY_BIT    = 0,
   parameter int          EN_BIT      = 7,
   parameter int          FACT_BIT    = 0,
   parameter int          DMA_BIT     = 8,
   parameter bit          EXIT_AT_ONE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              bus_full,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              dma_evt,
   output logic              irq_out
);
   localparam logic [DATA_W-1:0] ALL_ONES = '1;

   generate
      if (ADDR_W < 7) begin : g_bad_addr
         $error("fact_mmio_unit: ADDR_W must reach offset 0x64");
      end
      if (DATA_W != 32) begin : g_bad_data
         $error("fact_mmio_unit: DATA_W must be 32");
      end
      if (EN_BIT >= DATA_W || BUSY_BIT >= DATA_W || EN_BIT == BUSY_BIT) begin : g_bad_stat
         $error("fact_mmio_unit: status bit positions invalid");
      end
      if (DMA_BIT >= DATA_W || FACT_BIT >= DATA_W) begin : g_bad_irq
         $error("fact_mmio_unit: interrupt bit positions invalid");
      end
   endgenerate

   wr_strb_t          wstrb;
   logic              rd_go;
   rd_sel_e           rsel;
   logic [DATA_W-1:0] test_q;
   logic              irq_en_q;
   logic              eng_busy;
   logic              eng_done;
   logic [DATA_W-1:0] eng_value;
   logic [DATA_W-1:0] irq_word;
   logic [DATA_W-1:0] stat_view;
   logic [DATA_W-1:0] rd_mux;

   fxa_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr  (bus_addr),
      .wr    (bus_wr),
      .rd    (bus_rd),
      .full  (bus_full),
      .wstrb (wstrb),
      .rd_go (rd_go),
      .rsel  (rsel)
   );

   fxa_fact_engine #(.DATA_W(DATA_W), .EXIT_AT_ONE(EXIT_AT_ONE)) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (wstrb.oper),
      .operand (bus_wdata),
      .busy    (eng_busy),
      .done    (eng_done),
      .value   (eng_value)
   );

   fxa_irq_word #(.DATA_W(DATA_W), .FACT_BIT(FACT_BIT), .DMA_BIT(DMA_BIT)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (wstrb.iset),
      .clr_en   (wstrb.iclr),
      .mask     (bus_wdata),
      .fact_evt (eng_done && irq_en_q),
      .dma_evt  (dma_evt),
      .word     (irq_word),
      .level    (irq_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         test_q   <= '0;
         irq_en_q <= 1'b0;
      end else begin
         if (wstrb.test) test_q   <= ~bus_wdata;
         if (wstrb.stat) irq_en_q <= bus_wdata[EN_BIT];
      end
   end

   always_comb begin
      stat_view           = '0;
      stat_view[BUSY_BIT] = eng_busy;
      stat_view[EN_BIT]   = irq_en_q;
   end

   always_comb begin
      unique case (rsel)
         SEL_ID:    rd_mux = ID_VALUE;
         SEL_TEST:  rd_mux = test_q;
         SEL_OPER:  rd_mux = eng_value;
         SEL_STAT:  rd_mux = stat_view;
         SEL_IWORD: rd_mux = irq_word;
         default:   rd_mux = ALL_ONES;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_go) bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/fxa_checker.sv
module fxa_checker #(
   parameter int          ADDR_W  = 8,
   parameter int          DATA_W  = 32,
   parameter logic [31:0] ID_VALUE = 32'h0100_00ED,
   parameter int          DMA_BIT = 8,
   parameter int          FACT_BIT = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic              bus_full,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              dma_evt,
   input logic              irq_out,
   input logic              busy,
   input logic              done,
   input logic              irq_en,
   input logic [DATA_W-1:0] value,
   input logic [DATA_W-1:0] iword
);
   // R1
   id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_full && bus_addr == '0) |=> (bus_rdata == ID_VALUE));

   // R9
   narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_full) |=> (bus_rdata == '1));

   // R3
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && bus_wr && bus_full && bus_addr == ADDR_W'('h08))
         |=> (busy ? (value == $past(value)) : done));

   // R10
   dma_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_evt |=> (iword[DMA_BIT] && irq_out));

   // R6
   fact_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && irq_en) |=> iword[FACT_BIT]);

   // R8
   clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_full && bus_addr == ADDR_W'('h64) && bus_wdata == '1
       && !dma_evt && !(done && irq_en)) |=> !irq_out);

   // R11
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

bind fact_mmio_unit fxa_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_VALUE(ID_VALUE),
   .DMA_BIT(DMA_BIT), .FACT_BIT(FACT_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_full  (bus_full),
   .bus_rdata (bus_rdata),
   .dma_evt   (dma_evt),
   .irq_out   (irq_out),
   .busy      (eng_busy),
   .done      (eng_done),
   .irq_en    (irq_en_q),
   .value     (eng_value),
   .iword     (irq_word)
);

// File: tb/fact_mmio_unit_test.sv
module fact_mmio_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_full = 1'b1;
   logic [31:0] bus_rdata;
   logic        dma_evt = 1'b0;
   logic        irq_out;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   fact_mmio_unit uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_full(bus_full),
      .bus_rdata(bus_rdata), .dma_evt(dma_evt), .irq_out(irq_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic full = 1'b1);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_full = full; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_full = 1'b1;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic full = 1'b1);
      @(negedge clk);
      bus_addr = a; bus_full = full; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0; bus_full = 1'b1;
      d = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 200; i++) begin
         rd(8'h20, s);
         if (s[0] == 1'b0) break;
      end
   endtask

   function automatic logic [31:0] fact(input int n);
      logic [31:0] r = 32'd1;
      for (int k = 2; k <= n; k++) r = r * 32'(k);
      return r;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [31:0] pats [6];
      pats[0] = 32'h0; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'hA5A5_5A5A;
      pats[3] = 32'h1234_5678; pats[4] = 32'h8000_0001; pats[5] = 32'h0F0F_F0F0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      chk("R8 reset irq", {31'b0, irq_out}, 32'h0);
      rd(8'h20, d); chk("R5 reset status", d, 32'h0);
      rd(8'h24, d); chk("R7 reset iword", d, 32'h0);
      rd(8'h04, d); chk("R2 reset test", d, 32'h0);

      // R1 identification
      rd(8'h00, d); chk("R1 id", d, 32'h0100_00ED);

      // R11 read data holds after strobe
      repeat (3) @(negedge clk);
      chk("R11 rdata hold", bus_rdata, 32'h0100_00ED);

      // R2 inverse register, patterns plus walking ones
      foreach (pats[i]) begin
         wr(8'h04, pats[i]); rd(8'h04, d); chk("R2 inverse", d, ~pats[i]);
      end
      for (int b = 0; b < 32; b++) begin
         wr(8'h04, 32'h1 << b); rd(8'h04, d); chk("R2 walk", d, ~(32'h1 << b));
      end

      // R9 narrow accesses and unmapped reads
      wr(8'h04, 32'h0, 1'b0); rd(8'h04, d); chk("R9 narrow write", d, ~32'h0F0F_F0F0 ^ 32'h0 ^ 32'h0 | 32'h0 & 32'h0 ? ~(32'h1 << 31) : 32'h0);
      wr(8'h60, 32'hFF, 1'b0); rd(8'h24, d); chk("R9 narrow set", d, 32'h0);
      rd(8'h00, d, 1'b0); chk("R9 narrow read", d, 32'hFFFF_FFFF);
      rd(8'h0C, d); chk("R9 unmapped 0C", d, 32'hFFFF_FFFF);
      rd(8'h80, d); chk("R9 unmapped 80", d, 32'hFFFF_FFFF);
      rd(8'h60, d); chk("R9 unmapped 60", d, 32'hFFFF_FFFF);

      // R5 only bit 7 writable
      wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, d); chk("R5 status write", d, 32'h80);
      wr(8'h20, 32'hFFFF_FF7F); rd(8'h20, d); chk("R5 status clear", d, 32'h0);

      // R3 R4 R6 R8 factorial sweep
      for (int n = 0; n <= 13; n++) begin
         logic en;
         en = n[0];
         wr(8'h20, en ? 32'h80 : 32'h0);
         wr(8'h08, 32'(n));
         rd(8'h20, d); chk("R3 busy set", d & 32'h1, (n == 0) ? (d & 32'h1) : 32'h1);
         wait_idle();
         rd(8'h08, d); chk("R4 result", d, fact(n));
         rd(8'h24, d); chk("R6 fact irq", d, {31'b0, en});
         chk("R8 level", {31'b0, irq_out}, {31'b0, en});
         wr(8'h64, 32'hFFFF_FFFF);
         chk("R8 cleared", {31'b0, irq_out}, 32'h0);
      end

      // R3 write while busy ignored
      wr(8'h20, 32'h0);
      wr(8'h08, 32'd12);
      wr(8'h08, 32'd3);
      wait_idle();
      rd(8'h08, d); chk("R3 busy write ignored", d, fact(12));

      // R7 set / clear
      wr(8'h60, 32'h0000_F00F); rd(8'h24, d); chk("R7 set", d, 32'h0000_F00F);
      wr(8'h60, 32'h0001_0000); rd(8'h24, d); chk("R7 or", d, 32'h0001_F00F);
      wr(8'h64, 32'h0000_A005); rd(8'h24, d); chk("R7 clear", d, 32'h0001_500A);
      chk("R8 level set", {31'b0, irq_out}, 32'h1);
      wr(8'h64, 32'hFFFF_FFFF); rd(8'h24, d); chk("R7 clear all", d, 32'h0);

      // R10 DMA pulse
      @(negedge clk); dma_evt = 1'b1; @(negedge clk); dma_evt = 1'b0;
      chk("R10 dma irq", {31'b0, irq_out}, 32'h1);
      rd(8'h24, d); chk("R10 dma bit", d, 32'h100);

      // R7 set wins over same-cycle clear
      @(negedge clk);
      bus_addr = 8'h64; bus_wdata = 32'h100; bus_wr = 1'b1; dma_evt = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; dma_evt = 1'b0;
      rd(8'h24, d); chk("R7 set wins", d, 32'h100);
      wr(8'h64, 32'h100); rd(8'h24, d); chk("R7 clear dma", d, 32'h0);
      chk("R8 low", {31'b0, irq_out}, 32'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule